// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is a target on a two-wire serial bus. It presents a byte-addressed memory with a 14-bit address pointer. It watches SCL and the resolved SDA line, and it pulls SDA low through an output-enable only, so the pad is open drain. Three strap inputs set the device-select bits. The block answers only control bytes that carry the fixed device type 1010 and a select field equal to the straps.

A write transfer carries two address bytes that load the pointer. Any data bytes that follow are stored one by one. A read transfer returns bytes starting at the pointer, and continues for as long as the master acknowledges. The pointer persists across transfers, so one mechanism serves three read types:

- a current-address read, which is a read control byte alone;
- a random read, which is a dummy write of the address, then a repeated Start, then a read control byte;
- a sequential read, which is either of the above with master acknowledges.

The storage array is a parameterised power of two, `2**STORE_AW` bytes. Wider pointer values alias onto it modulo its size.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and the address pointer is 0, so a current-address read issued straight after reset returns the byte stored at address 0.
- R2: A control byte is acknowledged only when its upper seven bits, sent MSB first, equal 1010 followed by `strap_i[2:0]`. The last bit selects the direction: 1 is a read and 0 is a write. On a mismatch there is no acknowledge, and SDA stays released until the next Start.
- R3: In a write transfer the first byte after the control byte holds address bits 13..8 in its lower six bits, and its top two bits are ignored. The second byte holds address bits 7..0. Each byte is acknowledged, and together they load the pointer.
- R4: Each further data byte in a write transfer is acknowledged and stored at the pointer, and the pointer then advances by one.
- R5: A random read returns, MSB first, the byte at the address loaded by the preceding dummy write. The repeated Start ends the write but keeps the loaded pointer.
- R6: A current-address read returns the byte at the last accessed address plus one.
- R7: After each byte read, a master ACK (SDA low on the ninth clock) makes the block send the next sequential byte. A master NACK makes it release SDA and stay silent until a Start or Stop.
- R8: The pointer advances by one per byte read or written and wraps from 3FFF to 0000.
- R9: A Start or Stop returns the block to the state of waiting for a control byte, or to idle, and releases SDA. The pointer keeps its value across a Stop.
- R10: The block begins pulling SDA low only while SCL is low.
- R11: Storage is indexed by the low `STORE_AW` bits of the pointer, so with the default of 8, address 3FFF and address 00FF name the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Resolved bus data line as seen at the pad |
| strap_i | input | 3 | Device-select straps compared with the control byte |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach is the pointer wrap from 3FFF to 0000. It must happen both during a write and during a sequential read, and the data must be seen through the aliased storage. The stimulus first writes three bytes starting at 3FFE, which carries the pointer across the boundary in mid-write. It then reads the same three bytes back in one sequential read starting at 3FFE, and finishes with a random read at 00FF to expose the alias. A Stop between the dummy write and the read, and a second reset after the memory holds data, show that the pointer persists across a Stop and clears on reset.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int         PTR_W    = 14,
  parameter int         STORE_AW = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << STORE_AW;
  localparam int HI_W  = PTR_W - 8;

  typedef enum logic [2:0] {IDLE, CTRL, AHI, ALO, WDAT, RDAT} state_t;

  logic [2:0] scl_s, sda_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  logic scl_rise, scl_fall, scl_hi, start_det, stop_det;
  assign scl_rise  = scl_s[1] & ~scl_s[2];
  assign scl_fall  = ~scl_s[1] & scl_s[2];
  assign scl_hi    = scl_s[1] & scl_s[2];
  assign start_det = scl_hi & sda_s[2] & ~sda_s[1];
  assign stop_det  = scl_hi & ~sda_s[2] & sda_s[1];

  state_t             st;
  logic [3:0]         bitcnt;
  logic [7:0]         sr;
  logic [HI_W-1:0]    hi_q;
  logic [PTR_W-1:0]   ptr;
  logic               is_rd, acked, mack;
  logic [7:0]         mem [DEPTH];

  logic [7:0] rd_byte;
  logic       ctrl_match, live, fall8, fall9, rd_load, wr_stb, ptr_inc;
  assign rd_byte    = mem[ptr[STORE_AW-1:0]];
  assign ctrl_match = (sr[7:1] == {DEV_TYPE, strap_i});
  assign live       = (st != IDLE) && !start_det && !stop_det;
  assign fall8      = live && scl_fall && (bitcnt == 4'd8);
  assign fall9      = live && scl_fall && (bitcnt == 4'd9);
  assign rd_load    = fall9 && ((st == CTRL && acked && is_rd) || (st == RDAT && mack));
  assign wr_stb     = fall8 && (st == WDAT);
  assign ptr_inc    = rd_load || wr_stb;

  always_ff @(posedge clk)
    if (wr_stb) mem[ptr[STORE_AW-1:0]] <= sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      bitcnt <= '0;
      sr     <= '0;
      hi_q   <= '0;
      ptr    <= '0;
      is_rd  <= 1'b0;
      acked  <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= IDLE;
      sda_oe <= 1'b0;
    end else if (st != IDLE) begin
      if (ptr_inc) ptr <= ptr + 1'b1;
      if (scl_rise) begin
        if (bitcnt < 4'd8) sr <= {sr[6:0], sda_s[1]};
        else mack <= ~sda_s[1];
        bitcnt <= bitcnt + 1'b1;
      end
      if (fall8) begin
        case (st)
          CTRL: begin
            sda_oe <= ctrl_match;
            acked  <= ctrl_match;
            is_rd  <= sr[0];
          end
          AHI:  begin sda_oe <= 1'b1; hi_q <= sr[HI_W-1:0]; end
          ALO:  begin sda_oe <= 1'b1; ptr <= {hi_q, sr}; end
          WDAT: sda_oe <= 1'b1;
          default: sda_oe <= 1'b0;
        endcase
      end else if (fall9) begin
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (rd_load) begin
          st     <= RDAT;
          sr     <= rd_byte;
          sda_oe <= ~rd_byte[7];
        end else begin
          case (st)
            CTRL:    st <= acked ? AHI : IDLE;
            AHI:     st <= ALO;
            ALO:     st <= WDAT;
            WDAT:    st <= WDAT;
            default: st <= IDLE;
          endcase
        end
      end else if (scl_fall && st == RDAT) begin
        sda_oe <= ~sr[7];
      end
    end
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk #(
  parameter int PTR_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_h,
  input logic             sda_oe,
  input logic             stop_det,
  input logic             idle_q,
  input logic             ptr_inc,
  input logic [PTR_W-1:0] ptr
);
  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_h);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> !sda_oe);

  // R8
  ptr_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc |=> ptr == PTR_W'($past(ptr) + 1'b1));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_h    (scl_s[2]),
  .sda_oe   (sda_oe),
  .stop_det (stop_det),
  .idle_q   (st == IDLE),
  .ptr_inc  (ptr_inc),
  .ptr      (ptr)
);

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, viol = 0;
  logic [7:0] model [256];

  always @(posedge sda_oe) if (m_scl) viol++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic start_c;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic stop_c;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
    end
    m_sda = 1'b1; wq; m_scl = 1'b1; wq;
    ack = !sda_bus;
    wq; m_scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; m_scl = 1'b1; wq; b[i] = sda_bus; wq; m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
    m_sda = 1'b1;
  endtask

  task automatic set_addr(input logic [13:0] a, input string tag);
    bit ack;
    start_c;
    send_byte({4'b1010, STRAP, 1'b0}, ack); check(ack, {tag, " ctrl-w ack"}, ack, 1);
    send_byte({2'b11, a[13:8]}, ack);       check(ack, {tag, " hi ack"}, ack, 1);
    send_byte(a[7:0], ack);                 check(ack, {tag, " lo ack"}, ack, 1);
  endtask

  task automatic read_seq(input int n, input logic [13:0] first, input string tag);
    bit ack;
    logic [7:0] d;
    logic [13:0] a;
    a = first;
    send_byte({4'b1010, STRAP, 1'b1}, ack); check(ack, {tag, " ctrl-r ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, d);
      check(d === model[a[7:0]], tag, d, model[a[7:0]]);
      a = a + 1'b1;
    end
    stop_c;
  endtask

  task automatic t_reset;
    check(sda_oe === 1'b0, "R1 oe after reset", sda_oe, 0);
  endtask

  task automatic t_write(input logic [13:0] a, input int n, input logic [7:0] v0);
    bit ack;
    logic [13:0] p;
    set_addr(a, "R3");
    p = a;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = v0 + 8'(k * 17);
      send_byte(v, ack);
      check(ack, "R4 data ack", ack, 1);
      model[p[7:0]] = v;
      p = p + 1'b1;
    end
    stop_c;
  endtask

  task automatic t_random(input logic [13:0] a, input string tag);
    set_addr(a, tag);
    start_c;
    read_seq(1, a, tag);
  endtask

  task automatic t_current(input logic [13:0] a, input string tag);
    start_c;
    read_seq(1, a, tag);
  endtask

  task automatic t_mismatch;
    bit ack;
    start_c;
    send_byte({4'b1010, 3'b011, 1'b0}, ack);
    check(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 ignored after mismatch", ack, 0);
    stop_c;
    start_c;
    send_byte({4'b0110, STRAP, 1'b1}, ack);
    check(!ack, "R2 wrong device type nack", ack, 0);
    stop_c;
  endtask

  task automatic t_stop_keeps;
    set_addr(14'h0013, "R9");
    stop_c;
    check(sda_oe === 1'b0, "R9 released after stop", sda_oe, 0);
    t_current(14'h0013, "R9 pointer kept across stop");
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #2;
    t_reset;
    rst_n = 1'b1;
    wq;
    t_write(14'h0010, 6, 8'h3C);
    t_random(14'h0010, "R5 random read");
    t_current(14'h0011, "R6 current read");
    t_random(14'h0012, "R5 random 12");
    t_current(14'h0013, "R6 current after random");
    set_addr(14'h0010, "R7");
    start_c;
    read_seq(5, 14'h0010, "R7 sequential");
    t_current(14'h0015, "R7 pointer after sequence");
    t_mismatch;
    t_write(14'h3FFE, 3, 8'hA5);
    set_addr(14'h3FFE, "R8");
    start_c;
    read_seq(3, 14'h3FFE, "R8 wrap read");
    t_current(14'h0001, "R8 pointer after wrap");
    t_random(14'h00FF, "R11 alias of 3FFF");
    t_stop_keeps;
    rst_n = 1'b0; wq; rst_n = 1'b1; wq;
    t_current(14'h0000, "R1 pointer zero after reset");
    check(viol == 0, "R10 oe rise while scl high", viol, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule